// File: doc/BRIEF.md
# Processor Mode and Status Register Bank

This block keeps the processor's current status word in a register of its own and keeps one saved status word for each privileged mode. The mode code sits in the low five bits of the current status word. Ten modes exist: User, FIQ, IRQ and Supervisor come in both a 26-bit flavour and a 32-bit flavour, and Abort and Undefined come only in the 32-bit flavour. A configuration input decides which modes are allowed. In a 26-bit configuration only the four 26-bit modes are allowed. In the 32-bit configuration all ten are allowed.

A core drives the block with three kinds of request. An exception entry names a cause. The block saves the current status word into the saved register of the target mode, switches to that mode and sets the interrupt mask bits. A return copies the saved status word of the current mode back into the current status register. A status write loads a new word, but the block refuses any mode code that the configuration does not allow. Every update is registered and becomes visible on the outputs after the clock edge that accepts it.

Top module: `psr_mode_bank`

## Requirements
- R1: After reset, `status_o` is 0x000000C3. This is 26-bit Supervisor mode (code 5'h03) with the IRQ mask at bit 7 and the FIQ mask at bit 6 both set. `err_o` and `is32_o` are 0.
- R2: The mode codes are fixed. The 26-bit modes are User 5'h00, FIQ 5'h01, IRQ 5'h02 and Supervisor 5'h03. The 32-bit modes are User 5'h10, FIQ 5'h11, IRQ 5'h12, Supervisor 5'h13, Abort 5'h17 and Undefined 5'h1B. `mode_o` equals `status_o[4:0]`, and `is32_o` equals bit 4 of the mode code.
- R3: With `cfg_sel[1]`=1, an accepted entry selects the target mode from `exc_type`: 0 goes to 5'h11, 1 to 5'h12, 2 to 5'h13, 3 (prefetch abort) and 4 (data abort) to 5'h17, and 5 (undefined instruction) to 5'h1B. The entry sets bit 7. Entry into FIQ also sets bit 6. All other bits are kept.
- R4: With `cfg_sel` equal to 2'b00 or 2'b01, entry types 0, 1 and 2 go to 5'h01, 5'h02 and 5'h03, and types 3, 4 and 5 all go to 5'h03. In these configurations no write or restore can place a 32-bit mode code in the status word.
- R5: An entry stores the status word as it was before the entry into the saved register of the target mode. FIQ, IRQ, Supervisor, Abort and Undefined each have their own saved register, and both flavours of one mode share it.
- R6: A return made in a privileged mode loads the whole saved word of that mode into the current status register, subject to the mode check in R8.
- R7: A return made in either User mode leaves the status word unchanged.
- R8: In a privileged mode, a status write loads the whole word. A write or restore whose mode code is not allowed in the present configuration still loads the other bits, but the mode code stays as it was, and `err_o` is high for the one cycle after that edge. In every other cycle `err_o` is low.
- R9: A status write made in either User mode changes only bits 31..8. Bits 7..0 (mask bits and mode code) are kept.
- R10: When several requests arrive in the same cycle, entry wins over return and return wins over write. An entry of type 6 or 7 counts as no request, so a return or write in the same cycle goes ahead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Configuration. 00 and 01 allow only 26-bit modes. 1x allows all modes. |
| exc_req | input | 1 | Exception entry request |
| exc_type | input | 3 | Entry cause: 0 FIQ, 1 IRQ, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 undefined; 6 and 7 reserved |
| ret_req | input | 1 | Restore status from the current mode's saved register |
| wr_req | input | 1 | Status write request |
| wr_data | input | SW | Word for a status write |
| mode_o | output | 5 | Current mode code |
| status_o | output | SW | Current status word |
| is32_o | output | 1 | High when the current mode is a 32-bit mode |
| err_o | output | 1 | One-cycle pulse after a refused mode code |

## Verification
The hardest case to reach is a restore that the mode check refuses. The stimulus first selects the 32-bit configuration and takes an entry from 32-bit User mode, so the IRQ saved register holds a 32-bit mode code. It then switches the configuration to 26-bit and issues a return. The bench expects the restored upper bits, the unchanged IRQ mode code and an error pulse. A behavioural model of the status word and the five saved words is checked against the outputs after every edge. The stimulus also covers colliding requests, reserved entry types and User-mode writes.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int MODE_W = 5;
  localparam int CTRL_W = 8;
  localparam int I_BIT  = 7;
  localparam int F_BIT  = 6;
  localparam int NBANK  = 5;
  localparam int BIDX_W = $clog2(NBANK);

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t M_USR26 = 5'h00;
  localparam mode_t M_FIQ26 = 5'h01;
  localparam mode_t M_IRQ26 = 5'h02;
  localparam mode_t M_SVC26 = 5'h03;
  localparam mode_t M_USR32 = 5'h10;
  localparam mode_t M_FIQ32 = 5'h11;
  localparam mode_t M_IRQ32 = 5'h12;
  localparam mode_t M_SVC32 = 5'h13;
  localparam mode_t M_ABT32 = 5'h17;
  localparam mode_t M_UND32 = 5'h1B;

  localparam logic [BIDX_W-1:0] B_FIQ = 0;
  localparam logic [BIDX_W-1:0] B_IRQ = 1;
  localparam logic [BIDX_W-1:0] B_SVC = 2;
  localparam logic [BIDX_W-1:0] B_ABT = 3;
  localparam logic [BIDX_W-1:0] B_UND = 4;

  function automatic logic mode_legal(mode_t m, logic allow32);
    case (m)
      M_USR26, M_FIQ26, M_IRQ26, M_SVC26: mode_legal = 1'b1;
      M_USR32, M_FIQ32, M_IRQ32, M_SVC32,
      M_ABT32, M_UND32:                   mode_legal = allow32;
      default:                            mode_legal = 1'b0;
    endcase
  endfunction

  function automatic logic mode_has_bank(mode_t m);
    case (m)
      M_FIQ26, M_IRQ26, M_SVC26,
      M_FIQ32, M_IRQ32, M_SVC32, M_ABT32, M_UND32: mode_has_bank = 1'b1;
      default:                                     mode_has_bank = 1'b0;
    endcase
  endfunction

  function automatic logic [BIDX_W-1:0] mode_bank(mode_t m);
    case (m)
      M_FIQ26, M_FIQ32: mode_bank = B_FIQ;
      M_IRQ26, M_IRQ32: mode_bank = B_IRQ;
      M_SVC26, M_SVC32: mode_bank = B_SVC;
      M_ABT32:          mode_bank = B_ABT;
      M_UND32:          mode_bank = B_UND;
      default:          mode_bank = B_FIQ;
    endcase
  endfunction

  function automatic logic mode_is_user(mode_t m);
    mode_is_user = (m == M_USR26) || (m == M_USR32);
  endfunction
endpackage

// File: rtl/psr_exc_map.sv
module psr_exc_map
  import psr_pkg::*;
(
  input  logic [2:0] exc_type,
  input  logic       allow32,
  output mode_t      tgt,
  output logic       valid,
  output logic       fiq
);
  always_comb begin
    valid = 1'b1;
    fiq   = 1'b0;
    tgt   = M_SVC26;
    case (exc_type)
      3'd0: begin tgt = allow32 ? M_FIQ32 : M_FIQ26; fiq = 1'b1; end
      3'd1: tgt = allow32 ? M_IRQ32 : M_IRQ26;
      3'd2: tgt = allow32 ? M_SVC32 : M_SVC26;
      3'd3, 3'd4: tgt = allow32 ? M_ABT32 : M_SVC26;
      3'd5: tgt = allow32 ? M_UND32 : M_SVC26;
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank #(
  parameter int SW     = 32,
  parameter int NB     = 5,
  parameter int IDX_W  = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [SW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [SW-1:0]    rdata
);
  logic [SW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = (ridx < IDX_W'(NB)) ? mem[ridx] : '0;

  // R5: only a real saved register may be written
  p_widx_range_r5: assert property (@(posedge clk) disable iff (rst)
    we |-> (widx < IDX_W'(NB)));
endmodule

// File: rtl/psr_update.sv
module psr_update
  import psr_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic [SW-1:0]     cpsr,
  input  logic              allow32,
  input  logic              exc_req,
  input  logic              exc_valid,
  input  mode_t             exc_tgt,
  input  logic              exc_fiq,
  input  logic              ret_req,
  input  logic              wr_req,
  input  logic [SW-1:0]     wr_data,
  input  logic [SW-1:0]     rd_data,
  output logic [SW-1:0]     nxt,
  output logic              err_nxt,
  output logic              bank_we,
  output logic [BIDX_W-1:0] bank_widx,
  output logic [BIDX_W-1:0] bank_ridx
);
  mode_t cur_mode;
  assign cur_mode  = cpsr[MODE_W-1:0];
  assign bank_ridx = mode_bank(cur_mode);
  assign bank_widx = mode_bank(exc_tgt);

  always_comb begin
    nxt     = cpsr;
    err_nxt = 1'b0;
    bank_we = 1'b0;
    if (exc_req && exc_valid) begin
      bank_we             = 1'b1;
      nxt[MODE_W-1:0]     = exc_tgt;
      nxt[I_BIT]          = 1'b1;
      if (exc_fiq) nxt[F_BIT] = 1'b1;
    end else if (ret_req) begin
      if (mode_has_bank(cur_mode)) begin
        nxt = rd_data;
        if (!mode_legal(rd_data[MODE_W-1:0], allow32)) begin
          nxt[MODE_W-1:0] = cur_mode;
          err_nxt         = 1'b1;
        end
      end
    end else if (wr_req) begin
      if (mode_is_user(cur_mode)) begin
        nxt = {wr_data[SW-1:CTRL_W], cpsr[CTRL_W-1:0]};
      end else begin
        nxt = wr_data;
        if (!mode_legal(wr_data[MODE_W-1:0], allow32)) begin
          nxt[MODE_W-1:0] = cur_mode;
          err_nxt         = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psr_mode_bank.sv
module psr_mode_bank
  import psr_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_sel,
  input  logic          exc_req,
  input  logic [2:0]    exc_type,
  input  logic          ret_req,
  input  logic          wr_req,
  input  logic [SW-1:0] wr_data,
  output logic [4:0]    mode_o,
  output logic [SW-1:0] status_o,
  output logic          is32_o,
  output logic          err_o
);
  localparam logic [SW-1:0] RESET_WORD =
    SW'(M_SVC26) | (SW'(1) << I_BIT) | (SW'(1) << F_BIT);

  logic [SW-1:0]     cpsr, nxt, rd_data;
  logic              err_q, err_nxt;
  logic              allow32;
  mode_t             exc_tgt;
  logic              exc_valid, exc_fiq;
  logic              bank_we;
  logic [BIDX_W-1:0] bank_widx, bank_ridx;

  assign allow32 = cfg_sel[1];

  psr_exc_map u_map (
    .exc_type (exc_type),
    .allow32  (allow32),
    .tgt      (exc_tgt),
    .valid    (exc_valid),
    .fiq      (exc_fiq)
  );

  psr_saved_bank #(.SW(SW), .NB(NBANK), .IDX_W(BIDX_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (bank_we),
    .widx  (bank_widx),
    .wdata (cpsr),
    .ridx  (bank_ridx),
    .rdata (rd_data)
  );

  psr_update #(.SW(SW)) u_upd (
    .cpsr      (cpsr),
    .allow32   (allow32),
    .exc_req   (exc_req),
    .exc_valid (exc_valid),
    .exc_tgt   (exc_tgt),
    .exc_fiq   (exc_fiq),
    .ret_req   (ret_req),
    .wr_req    (wr_req),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .nxt       (nxt),
    .err_nxt   (err_nxt),
    .bank_we   (bank_we),
    .bank_widx (bank_widx),
    .bank_ridx (bank_ridx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr  <= RESET_WORD;
      err_q <= 1'b0;
    end else begin
      cpsr  <= nxt;
      err_q <= err_nxt;
    end
  end

  assign status_o = cpsr;
  assign mode_o   = cpsr[MODE_W-1:0];
  assign is32_o   = cpsr[MODE_W-1];
  assign err_o    = err_q;

  // R1: first cycle out of reset shows the reset word
  p_reset_word_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o == RESET_WORD && !err_o));

  // R4: a 26-bit configuration never moves into a 32-bit mode
  p_cfg26_no32_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_sel[1]) && !$past(rst) && mode_o != $past(mode_o)) |-> !mode_o[4]);

  // R3: any accepted entry leaves the IRQ mask set
  p_entry_mask_r3: assert property (@(posedge clk) disable iff (rst)
    $past(exc_req && exc_valid) |-> status_o[I_BIT]);

  // R7: return from a user mode changes nothing
  p_user_ret_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ret_req && !(exc_req && exc_valid) && mode_is_user(mode_o))
      |-> $stable(status_o));

  // R8: an error pulse follows a write or restore and keeps the mode
  p_err_src_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($past(ret_req || wr_req) && $stable(mode_o)));
endmodule

// File: tb/psr_mode_bank_tb.sv
`timescale 1ns/1ps
module psr_mode_bank_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_sel;
  logic        exc_req, ret_req, wr_req;
  logic [2:0]  exc_type;
  logic [31:0] wr_data;
  logic [4:0]  mode_o;
  logic [31:0] status_o;
  logic        is32_o, err_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_st;
  logic [31:0] m_bank [5];
  logic        m_err;

  always #5 clk = ~clk;

  psr_mode_bank #(.SW(32)) u_dut (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .exc_req(exc_req),
    .exc_type(exc_type), .ret_req(ret_req), .wr_req(wr_req),
    .wr_data(wr_data), .mode_o(mode_o), .status_o(status_o),
    .is32_o(is32_o), .err_o(err_o)
  );

  function automatic int bidx(logic [4:0] m);
    case (m)
      5'h01, 5'h11: return 0;
      5'h02, 5'h12: return 1;
      5'h03, 5'h13: return 2;
      5'h17:        return 3;
      5'h1B:        return 4;
      default:      return -1;
    endcase
  endfunction

  function automatic bit legal(logic [4:0] m, logic [1:0] c);
    if (m <= 5'h03) return 1;
    if (!c[1]) return 0;
    return (m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
            m == 5'h17 || m == 5'h1B);
  endfunction

  function automatic logic [4:0] target(logic [2:0] t, logic [1:0] c);
    logic [4:0] w32 [6] = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h17, 5'h1B};
    logic [4:0] w26 [6] = '{5'h01, 5'h02, 5'h03, 5'h03, 5'h03, 5'h03};
    return c[1] ? w32[t] : w26[t];
  endfunction

  task automatic compare(input string tag);
    n_run++;
    if (status_o !== m_st || err_o !== m_err || mode_o !== m_st[4:0] ||
        is32_o !== m_st[4]) begin
      n_fail++;
      $display("FAIL %s: status=%h err=%b mode=%h is32=%b expected status=%h err=%b",
               tag, status_o, err_o, mode_o, is32_o, m_st, m_err);
    end
  endtask

  task automatic step(input logic e, input logic [2:0] t, input logic r,
                      input logic w, input logic [31:0] d,
                      input logic [1:0] c, input string tag);
    int b;
    logic [31:0] nx;
    exc_req = e; exc_type = t; ret_req = r; wr_req = w; wr_data = d;
    cfg_sel = c;
    nx = m_st;
    m_err = 1'b0;
    if (e && t <= 3'd5) begin
      logic [4:0] tg;
      tg = target(t, c);
      m_bank[bidx(tg)] = m_st;
      nx[4:0] = tg;
      nx[7] = 1'b1;
      if (t == 3'd0) nx[6] = 1'b1;
    end else if (r) begin
      b = bidx(m_st[4:0]);
      if (b >= 0) begin
        nx = m_bank[b];
        if (!legal(nx[4:0], c)) begin nx[4:0] = m_st[4:0]; m_err = 1'b1; end
      end
    end else if (w) begin
      if (m_st[4:0] == 5'h00 || m_st[4:0] == 5'h10) begin
        nx = {d[31:8], m_st[7:0]};
      end else begin
        nx = d;
        if (!legal(d[4:0], c)) begin nx[4:0] = m_st[4:0]; m_err = 1'b1; end
      end
    end
    m_st = nx;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_sel = 2'b00; exc_req = 0; exc_type = 0;
    ret_req = 0; wr_req = 0; wr_data = '0;
    m_st = 32'h0000_00C3; m_err = 0;
    for (int i = 0; i < 5; i++) m_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset word");
    step(0, 0, 0, 0, 0, 2'b00, "R1 idle after reset");
    // 26-bit configuration
    step(0, 0, 0, 1, 32'h0000_0013, 2'b00, "R8 32-bit mode refused in cfg 00");
    step(1, 3'd1, 0, 0, 0, 2'b00, "R4 IRQ entry 26-bit");
    step(0, 0, 1, 0, 0, 2'b00, "R6 return from IRQ26");
    step(1, 3'd5, 0, 0, 0, 2'b01, "R4 undefined maps to SVC26");
    step(1, 3'd4, 0, 0, 0, 2'b01, "R4 data abort maps to SVC26");
    step(0, 0, 0, 1, 32'h0000_0017, 2'b01, "R4 abort code refused in cfg 01");
    step(1, 3'd0, 0, 0, 0, 2'b00, "R4 FIQ entry 26-bit sets both masks");
    step(0, 0, 1, 0, 0, 2'b00, "R6 return from FIQ26");
    // 32-bit configuration
    step(0, 0, 0, 1, 32'h1200_0013, 2'b10, "R8 write selects SVC32");
    step(1, 3'd0, 0, 0, 0, 2'b10, "R3 FIQ32 entry");
    step(1, 3'd3, 0, 0, 0, 2'b10, "R3 prefetch abort to ABT32");
    step(1, 3'd5, 0, 0, 0, 2'b11, "R3 undefined to UND32");
    step(0, 0, 1, 0, 0, 2'b10, "R6 return from UND32");
    step(0, 0, 1, 0, 0, 2'b10, "R5 return from ABT32");
    step(0, 0, 0, 1, 32'h3300_0005, 2'b10, "R8 illegal code 05 refused");
    step(0, 0, 0, 0, 0, 2'b10, "R8 error lasts one cycle");
    step(1, 3'd6, 0, 1, 32'h4400_0012, 2'b10, "R10 reserved type ignored");
    step(1, 3'd7, 1, 0, 0, 2'b10, "R10 reserved type, return proceeds");
    step(1, 3'd1, 1, 1, 32'h0000_0010, 2'b10, "R10 entry wins collision");
    step(0, 0, 1, 1, 32'h0000_0010, 2'b10, "R10 return beats write");
    step(0, 0, 0, 1, 32'hA500_0010, 2'b10, "R2 write selects USR32");
    step(0, 0, 0, 1, 32'h5A00_00D3, 2'b10, "R9 user write keeps low byte");
    step(0, 0, 1, 0, 0, 2'b10, "R7 return in USR32 ignored");
    step(1, 3'd2, 0, 0, 0, 2'b10, "R3 supervisor call from user");
    step(0, 0, 1, 0, 0, 2'b10, "R6 return to USR32");
    step(1, 3'd1, 0, 0, 0, 2'b10, "R5 IRQ32 entry saves user word");
    step(0, 0, 1, 0, 0, 2'b00, "R8 restore of 32-bit code refused in cfg 00");
    step(0, 0, 0, 1, 32'h0000_0000, 2'b00, "R2 write selects USR26");
    step(0, 0, 0, 1, 32'hFFFF_FF13, 2'b00, "R9 USR26 write keeps low byte");
    step(0, 0, 1, 0, 0, 2'b00, "R7 return in USR26 ignored");
    step(1, 3'd2, 0, 0, 0, 2'b00, "R5 SVC26 entry from user");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule